// File: doc/BRIEF.md
# Register File with Pointer Pair

This block is the 32-entry, 8-bit working register store of a small 8-bit core. Two combinational read ports serve register-to-register and single-register operations. One synchronous write port updates a register at the clock edge. The first read port and the write port can also run in an immediate-operand mode, in which a 4-bit register field reaches only the upper sixteen registers.

The two highest registers also form a 16-bit pointer. The pointer is always visible as one 16-bit output. It can be loaded as a whole in a single cycle through its own enable. When the pointer selects a register inside the file, only the lowest five bits of the pointer's low byte are used. An indirect read port returns the register the pointer selects. An indirect write mode sends the write data to that register.

Top module: `regf_core`

## Requirements
- R1: While reset is high at a clock edge, every register is cleared to zero. After reset, every read port and the pointer output return zero until a write happens.
- R2: With immediate mode off, read ports A and B return the register chosen by their 5-bit index, for any of the 32 registers. A write with `wr_en_i` high stores `wr_data_i` into the register chosen by `wr_idx_i`, and the new value is visible from the next cycle.
- R3: In immediate mode (`rd_a_imm_i` for port A, `wr_imm_i` for the write port), the target register is 16 plus the low four bits of the index. Bit 4 of the index is ignored.
- R4: `ptr_o` equals register 31 in bits 15:8 and register 30 in bits 7:0.
- R5: `ind_data_o` returns the register whose number is bits 4:0 of register 30. Register 31 and bits 7:5 of register 30 have no effect on the choice.
- R6: When `wr_ind_i` is high, a write goes to the register chosen by bits 4:0 of register 30 as it stood before the edge. `wr_idx_i` and `wr_imm_i` are ignored in this case.
- R7: A read port whose register is being written in the same cycle returns the value being written rather than the stored value. This applies to ports A, B and the indirect port, and to both the byte write and the pointer write.
- R8: `ptr_wr_en_i` loads `ptr_wr_data_i[7:0]` into register 30 and `ptr_wr_data_i[15:8]` into register 31 in one cycle. It overrides a byte write aimed at register 30 or 31 in the same cycle. A byte write to any other register in that cycle still takes place.
- R9: With `wr_en_i` and `ptr_wr_en_i` both low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx_i | input | 5 | Port A register index |
| rd_a_imm_i | input | 1 | Port A immediate-mode addressing (upper half only) |
| rd_b_idx_i | input | 5 | Port B register index |
| wr_en_i | input | 1 | Byte write enable |
| wr_imm_i | input | 1 | Write uses immediate-mode addressing |
| wr_ind_i | input | 1 | Write target chosen by the pointer |
| wr_idx_i | input | 5 | Write register index |
| wr_data_i | input | 8 | Write data |
| ptr_wr_en_i | input | 1 | Load both pointer bytes |
| ptr_wr_data_i | input | 16 | Pointer load value |
| rd_a_data_o | output | 8 | Port A read data |
| rd_b_data_o | output | 8 | Port B read data |
| ind_data_o | output | 8 | Register chosen by the pointer |
| ptr_o | output | 16 | 16-bit pointer from the top register pair |

## Verification
The hardest case to reach from the ports is a same-cycle conflict on the pointer pair. In this case a pointer load meets a byte write aimed at register 30 or 31, or an indirect write happens while the pointer's high byte and the top bits of its low byte are non-zero. Directed cycles first set up a pointer with junk in its ignored bits. They then issue a pointer load, an indirect write and a colliding byte write together, and check all three read ports in the conflict cycle as well as the cycle after. A long random phase follows. It biases write indices toward registers 30 and 31 and mixes all addressing modes, so that conflicts and write-through reads keep recurring.

// File: rtl/regf_pkg.sv
package regf_pkg;

    localparam int DATA_W   = 8;
    localparam int NUM_REGS = 32;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int IMM_W    = IDX_W - 1;
    localparam int PTR_W    = 2 * DATA_W;
    localparam int NUM_RD   = 3;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    localparam idx_t PTR_LO_IDX = idx_t'(NUM_REGS - 2);
    localparam idx_t PTR_HI_IDX = idx_t'(NUM_REGS - 1);

    typedef enum logic [1:0] {
        ADDR_FULL = 2'd0,
        ADDR_IMM  = 2'd1,
        ADDR_PTR  = 2'd2
    } addr_mode_e;

    typedef struct packed {
        logic  en;
        idx_t  idx;
        byte_t data;
    } byte_wr_t;

    typedef struct packed {
        logic en;
        ptr_t data;
    } ptr_wr_t;

    function automatic idx_t map_addr(addr_mode_e mode, idx_t field, byte_t ptr_lo);
        idx_t r;
        case (mode)
            ADDR_IMM: r = {1'b1, field[IMM_W-1:0]};
            ADDR_PTR: r = ptr_lo[IDX_W-1:0];
            default:  r = field;
        endcase
        return r;
    endfunction

    // Value a register holds after the coming edge; pointer load wins.
    function automatic byte_t next_val(idx_t i, byte_wr_t w, ptr_wr_t p, byte_t cur);
        byte_t r;
        if (p.en && i == PTR_LO_IDX)      r = p.data[DATA_W-1:0];
        else if (p.en && i == PTR_HI_IDX) r = p.data[PTR_W-1:DATA_W];
        else if (w.en && w.idx == i)      r = w.data;
        else                              r = cur;
        return r;
    endfunction

endpackage

// File: rtl/regf_addr_map.sv
module regf_addr_map
    import regf_pkg::*;
(
    input  addr_mode_e mode,
    input  idx_t       field,
    input  byte_t      ptr_lo,
    output idx_t       idx
);

    assign idx = map_addr(mode, field, ptr_lo);

endmodule

// File: rtl/regf_storage.sv
module regf_storage
    import regf_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  byte_wr_t                         wr,
    input  ptr_wr_t                          pw,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) regs_q[g] <= '0;
            else     regs_q[g] <= next_val(idx_t'(g), wr, pw, regs_q[g]);
        end
    end

endmodule

// File: rtl/regf_read_port.sv
module regf_read_port
    import regf_pkg::*;
(
    input  idx_t                             idx,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q,
    input  byte_wr_t                         wr,
    input  ptr_wr_t                          pw,
    output byte_t                            data
);

    assign data = next_val(idx, wr, pw, regs_q[idx]);

endmodule

// File: rtl/regf_core.sv
module regf_core
    import regf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  rd_a_idx_i,
    input  logic        rd_a_imm_i,
    input  logic [4:0]  rd_b_idx_i,
    input  logic        wr_en_i,
    input  logic        wr_imm_i,
    input  logic        wr_ind_i,
    input  logic [4:0]  wr_idx_i,
    input  logic [7:0]  wr_data_i,
    input  logic        ptr_wr_en_i,
    input  logic [15:0] ptr_wr_data_i,
    output logic [7:0]  rd_a_data_o,
    output logic [7:0]  rd_b_data_o,
    output logic [7:0]  ind_data_o,
    output logic [15:0] ptr_o
);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
    byte_wr_t   wr;
    ptr_wr_t    pw;
    addr_mode_e wr_mode;
    idx_t       wr_idx;

    addr_mode_e rd_mode [NUM_RD];
    idx_t       rd_field[NUM_RD];
    idx_t       rd_idx  [NUM_RD];
    byte_t      rd_data [NUM_RD];

    assign wr_mode = wr_ind_i ? ADDR_PTR : (wr_imm_i ? ADDR_IMM : ADDR_FULL);

    regf_addr_map u_wmap (
        .mode   (wr_mode),
        .field  (wr_idx_i),
        .ptr_lo (regs_q[PTR_LO_IDX]),
        .idx    (wr_idx)
    );

    assign wr = '{en: wr_en_i, idx: wr_idx, data: wr_data_i};
    assign pw = '{en: ptr_wr_en_i, data: ptr_wr_data_i};

    regf_storage u_store (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .pw     (pw),
        .regs_q (regs_q)
    );

    // Port 0: A (full or immediate), port 1: B (full), port 2: indirect.
    assign rd_mode[0]  = rd_a_imm_i ? ADDR_IMM : ADDR_FULL;
    assign rd_field[0] = rd_a_idx_i;
    assign rd_mode[1]  = ADDR_FULL;
    assign rd_field[1] = rd_b_idx_i;
    assign rd_mode[2]  = ADDR_PTR;
    assign rd_field[2] = '0;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        regf_addr_map u_map (
            .mode   (rd_mode[p]),
            .field  (rd_field[p]),
            .ptr_lo (regs_q[PTR_LO_IDX]),
            .idx    (rd_idx[p])
        );
        regf_read_port u_port (
            .idx    (rd_idx[p]),
            .regs_q (regs_q),
            .wr     (wr),
            .pw     (pw),
            .data   (rd_data[p])
        );
    end

    assign rd_a_data_o = rd_data[0];
    assign rd_b_data_o = rd_data[1];
    assign ind_data_o  = rd_data[2];
    assign ptr_o       = {regs_q[PTR_HI_IDX], regs_q[PTR_LO_IDX]};

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
        ptr_wr_en_i |=> ptr_o == $past(ptr_wr_data_i)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_i && !ptr_wr_en_i) |=> $stable(ptr_o) && $stable(regs_q)); // R9

    AST_IMM_UPPER: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_imm_i && !wr_ind_i && !ptr_wr_en_i)
        |=> regs_q[{1'b1, $past(wr_idx_i[3:0])}] == $past(wr_data_i)); // R3

    AST_IND_SELECT: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_i && !ptr_wr_en_i) |-> ind_data_o == regs_q[ptr_o[4:0]]); // R5

    AST_FULL_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !wr_imm_i && !wr_ind_i && !ptr_wr_en_i)
        |=> regs_q[$past(wr_idx_i)] == $past(wr_data_i)); // R2

endmodule

// File: tb/sim_regf_core.sv
module sim_regf_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  rd_a_idx_i = '0;
    logic        rd_a_imm_i = 1'b0;
    logic [4:0]  rd_b_idx_i = '0;
    logic        wr_en_i = 1'b0;
    logic        wr_imm_i = 1'b0;
    logic        wr_ind_i = 1'b0;
    logic [4:0]  wr_idx_i = '0;
    logic [7:0]  wr_data_i = '0;
    logic        ptr_wr_en_i = 1'b0;
    logic [15:0] ptr_wr_data_i = '0;
    logic [7:0]  rd_a_data_o, rd_b_data_o, ind_data_o;
    logic [15:0] ptr_o;

    int checks = 0;
    int failures = 0;
    int model[32];
    bit prev_ind = 0, prev_coll = 0, prev_idle = 0;

    always #10 clk = ~clk;

    regf_core u0 (
        .clk(clk), .rst(rst),
        .rd_a_idx_i(rd_a_idx_i), .rd_a_imm_i(rd_a_imm_i), .rd_b_idx_i(rd_b_idx_i),
        .wr_en_i(wr_en_i), .wr_imm_i(wr_imm_i), .wr_ind_i(wr_ind_i),
        .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
        .ptr_wr_en_i(ptr_wr_en_i), .ptr_wr_data_i(ptr_wr_data_i),
        .rd_a_data_o(rd_a_data_o), .rd_b_data_o(rd_b_data_o),
        .ind_data_o(ind_data_o), .ptr_o(ptr_o)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // One cycle: drive at negedge, compare combinational outputs, update model at posedge.
    task automatic cycle(input bit aimm, input int ra, input int rb,
                         input bit we, input bit wimm, input bit wind, input int widx,
                         input int wd, input bit pwe, input int pd);
        int nm[32];
        int wt, ea, ei;
        rd_a_imm_i = aimm; rd_a_idx_i = 5'(ra); rd_b_idx_i = 5'(rb);
        wr_en_i = we; wr_imm_i = wimm; wr_ind_i = wind; wr_idx_i = 5'(widx);
        wr_data_i = 8'(wd); ptr_wr_en_i = pwe; ptr_wr_data_i = 16'(pd);
        #2;
        if (wind)      wt = model[30] % 32;
        else if (wimm) wt = 16 + (widx % 16);
        else           wt = widx % 32;
        for (int i = 0; i < 32; i++) begin
            if (pwe && i == 30)      nm[i] = pd % 256;
            else if (pwe && i == 31) nm[i] = (pd / 256) % 256;
            else if (we && wt == i)  nm[i] = wd % 256;
            else                     nm[i] = model[i];
        end
        ea = aimm ? 16 + (ra % 16) : ra % 32;
        ei = model[30] % 32;
        check(aimm ? "R3" : ((we && wt == ea) || pwe ? "R7" : "R2"), "port A",
              int'(rd_a_data_o), nm[ea]);
        check(prev_ind ? "R6" : (prev_idle ? "R9" : "R2"), "port B",
              int'(rd_b_data_o), nm[rb % 32]);
        check("R5", "indirect", int'(ind_data_o), nm[ei]);
        check(prev_coll ? "R8" : "R4", "pointer", int'(ptr_o), model[31] * 256 + model[30]);
        @(posedge clk);
        for (int i = 0; i < 32; i++) model[i] = nm[i];
        prev_ind  = we && wind && !(pwe && wt >= 30);
        prev_coll = pwe;
        prev_idle = !we && !pwe;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 32; i++) model[i] = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        // R1: everything zero after reset
        check("R1", "ptr after reset", int'(ptr_o), 0);
        check("R1", "port A after reset", int'(rd_a_data_o), 0);
        check("R1", "indirect after reset", int'(ind_data_o), 0);
        rd_b_idx_i = 5'd31; #1;
        check("R1", "port B r31 after reset", int'(rd_b_data_o), 0);

        // R2: fill every register through the full-range write
        for (int i = 0; i < 32; i++) cycle(0, i, (i + 31) % 32, 1, 0, 0, i, i * 7 + 3, 0, 0);
        for (int i = 0; i < 32; i++) cycle(0, i, 31 - i, 0, 0, 0, 0, 0, 0, 0);
        // R3: immediate writes with index bit 4 set and clear
        cycle(1, 5, 21, 1, 1, 0, 5, 8'hA5, 0, 0);
        cycle(1, 21, 21, 1, 1, 0, 21, 8'h5A, 0, 0);
        cycle(1, 31, 15, 0, 0, 0, 0, 0, 0, 0);
        // R8: pointer load with junk high byte and bits 7:5, colliding with byte write to R30
        cycle(0, 30, 31, 1, 0, 0, 30, 8'h77, 1, 16'hC3E9);
        cycle(0, 30, 31, 1, 0, 0, 31, 8'h66, 1, 16'h9AEC);
        // R8: pointer load plus byte write to another register in the same cycle
        cycle(0, 4, 12, 1, 0, 0, 4, 8'h44, 1, 16'hFFE6);
        // R6: indirect write, wr_idx and wr_imm ignored
        cycle(0, 6, 6, 1, 1, 1, 9, 8'hD2, 0, 0);
        cycle(0, 6, 9, 0, 0, 0, 0, 0, 0, 0);
        // R6 + R8: indirect write while the pointer is being reloaded
        cycle(0, 6, 6, 1, 0, 1, 3, 8'h3C, 1, 16'h1F0B);
        cycle(0, 11, 6, 0, 0, 0, 0, 0, 0, 0);
        // R7: indirect write onto the pointer's own low byte
        ptr_wr_data_i = '0;
        cycle(0, 30, 30, 0, 0, 0, 0, 0, 1, 16'h005E);
        cycle(0, 30, 30, 1, 0, 1, 0, 8'h07, 0, 0);
        cycle(0, 30, 7, 0, 0, 0, 0, 0, 0, 0);

        // Random mix, biased toward the pointer pair
        for (int n = 0; n < 4000; n++) begin
            int widx;
            widx = ($urandom % 4 == 0) ? 30 + ($urandom % 2) : $urandom % 32;
            cycle($urandom % 3 == 0, $urandom % 32, $urandom % 32,
                  $urandom % 3 != 0, $urandom % 4 == 0, $urandom % 5 == 0, widx,
                  $urandom % 256, $urandom % 6 == 0, $urandom % 65536);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule